// File: doc/BRIEF.md
# Nibble-Bus Host Command Interface

This block is the device side of a narrow command port through which a host microcontroller configures a disc-playback controller and reads status from it. The host owns three wires: an active-low select, a transfer clock that idles high, and a shared 4-bit data bus. The device drives that bus open-drain, so it never drives a line high. Each bus bit has an output enable, and an enabled bit pulls its line low. Released lines float high through pull-ups.

Every transaction opens with a status nibble that the device presents as soon as select goes low, before any clock. On the first falling clock edge the device releases the bus, and the host then presents nibbles that are captured on rising edges. The first nibble is an opcode.

- An opcode with bit 3 clear is a register write. The following nibbles form the register value and are followed by an acknowledge nibble.
- An opcode with bit 3 set is a read. The device returns a status word one nibble per falling edge and then a parity nibble.
- A select pulse with no clocks is an idle transaction, which returns the status nibble only.

The select and transfer clock are oversampled and synchronised in the fast system clock domain.

Top module: `nibble_cmd_port`

## Requirements
- R1: After reset the bus is released (bus_oe = 0) and every configuration register reads 0.
- R2: Within three system clocks after ce_n falls, and with no transfer clock edge, the device drives the dev_status value that was present at that moment. A driven nibble value V appears as bus_oe = ~V.
- R3: The first falling transfer clock edge after select releases the bus so that the host can drive it.
- R4: An opcode whose bit 3 is 0 is a write, and bits 2:0 are the register address. The next REG_NIBS nibbles, most significant first, become that register's value, committed after the last nibble. The bus stays released while the nibbles are captured.
- R5: After the last write nibble the device drives acknowledge 4'hA for an address below NUM_REGS (0 to 5 by default). For addresses 6 and 7 it drives 4'h5 and leaves every register unchanged.
- R6: The acknowledge stays on the bus until the next falling transfer clock edge, which releases the bus.
- R7: An opcode whose bit 3 is 1 is a read, and bits 2:0 select a status word. Each following falling edge drives the next nibble of that word, most significant first, and rising edges leave the nibble in place.
- R8: After the last data nibble, the next falling edge drives a parity nibble equal to the XOR of all the word's nibbles. The falling edge after that releases the bus.
- R9: When ce_n rises, the bus is released within three system clocks and the transaction is abandoned. A write that has not received all its nibbles changes no register.
- R10: In an idle transaction the status nibble is held for as long as select stays low without clocks.
- R11: Transfer clock edges that arrive after a transaction has completed, or while select is high, are ignored. The bus stays released and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the transfer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Host select, active low, asynchronous |
| xfer_clk | input | 1 | Host transfer clock, idles high, asynchronous |
| bus_in | input | 4 | Sensed level of the shared bus |
| bus_oe | output | 4 | Per-bit pull-down enable (1 drives the line low) |
| dev_status | input | 4 | Status nibble presented at the start of each transaction |
| stat_words | input | NUM_STAT*STAT_NIBS*4 | Readable status words, word i at bits i*8 +: 8 by default |
| cfg_regs | output | NUM_REGS*REG_NIBS*4 | Configuration registers, register i at bits i*8 +: 8 by default |

## Verification
A change on ce_n or xfer_clk passes through two synchroniser flops and one edge-history flop, and the sequencer registers its response on the next edge. bus_oe therefore responds on the third rising system clock edge after the pin change. A register write becomes visible on cfg_regs one edge after the acknowledge appears. The bench makes every host pin change at a falling system clock edge and then waits eight full cycles before it pushes an expectation. It also holds each transfer clock phase for that long, so each result has settled before it is compared and has not yet been replaced by the next host step. Each check is pushed into a scoreboard queue at that settled point, and a monitor compares it against the ports.

// File: rtl/nbi_pkg.sv
package nbi_pkg;
    localparam int NIB_W = 4;
    localparam int SEL_W = 3;
    localparam logic [NIB_W-1:0] ACK_OK  = 4'hA;
    localparam logic [NIB_W-1:0] ACK_BAD = 4'h5;

    typedef enum logic [2:0] {
        S_OFF,
        S_STATUS,
        S_CMD,
        S_WDATA,
        S_ACK,
        S_RDATA,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/nbi_sync.sv
module nbi_sync #(
    parameter int             W       = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = d_in;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: RST_VAL, s2: RST_VAL, s3: RST_VAL};
        else        q <= d;
    end

    assign lvl  = q.s2;
    assign rise = q.s2 & ~q.s3;
    assign fall = ~q.s2 & q.s3;
endmodule

// File: rtl/nbi_regbank.sv
module nbi_regbank #(
    parameter int NUM_REGS = 6,
    parameter int REG_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [2:0]                wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [REG_W-1:0] r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (wr_en && wr_addr == 3'(i)) r_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= r_d;
        end

        assign regs_o[i*REG_W +: REG_W] = r_q;
    end
endmodule

// File: rtl/nbi_rdmux.sv
module nbi_rdmux #(
    parameter int NUM_STAT  = 8,
    parameter int STAT_NIBS = 2,
    localparam int STAT_W   = STAT_NIBS * 4
) (
    input  logic [NUM_STAT*STAT_W-1:0] stat_words,
    input  logic [2:0]                 sel,
    output logic [STAT_W-1:0]          word,
    output logic [3:0]                 par
);
    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_STAT; i++) begin
            if (sel == 3'(i)) word = stat_words[i*STAT_W +: STAT_W];
        end
        par = '0;
        for (int k = 0; k < STAT_NIBS; k++) begin
            par = par ^ word[k*4 +: 4];
        end
    end
endmodule

// File: rtl/nbi_seq.sv
module nbi_seq
    import nbi_pkg::*;
#(
    parameter int NUM_REGS  = 6,
    parameter int REG_NIBS  = 2,
    parameter int STAT_NIBS = 2,
    localparam int REG_W    = REG_NIBS * NIB_W,
    localparam int STAT_W   = STAT_NIBS * NIB_W,
    localparam int MAXN     = (REG_NIBS > STAT_NIBS) ? REG_NIBS : STAT_NIBS,
    localparam int CNT_W    = $clog2(MAXN + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_hi,
    input  logic              ce_fall,
    input  logic              x_rise,
    input  logic              x_fall,
    input  logic [NIB_W-1:0]  bus_in,
    input  logic [NIB_W-1:0]  dev_status,
    input  logic [STAT_W-1:0] rd_word,
    input  logic [NIB_W-1:0]  rd_par,
    output logic [SEL_W-1:0]  rd_sel,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_addr,
    output logic [REG_W-1:0]  wr_data,
    output logic              drv_en,
    output logic [NIB_W-1:0]  drv_val
);
    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [SEL_W-1:0]  addr;
        logic [REG_W-1:0]  wbuf;
        logic [STAT_W-1:0] rbuf;
        logic [NIB_W-1:0]  par;
        logic              drv_en;
        logic [NIB_W-1:0]  drv_val;
        logic              wr_en;
    } seq_t;

    seq_t q, d;
    logic legal;

    assign legal  = int'(q.addr) < NUM_REGS;
    assign rd_sel = bus_in[SEL_W-1:0];

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (ce_hi) begin
            d.st     = S_OFF;
            d.drv_en = 1'b0;
            d.cnt    = '0;
        end else if (ce_fall) begin
            d.st      = S_STATUS;
            d.drv_en  = 1'b1;
            d.drv_val = dev_status;
            d.cnt     = '0;
        end else begin
            case (q.st)
                S_STATUS: begin
                    if (x_fall) begin
                        d.st     = S_CMD;
                        d.drv_en = 1'b0;
                    end
                end
                S_CMD: begin
                    if (x_rise) begin
                        d.addr = bus_in[SEL_W-1:0];
                        d.cnt  = '0;
                        if (bus_in[NIB_W-1]) begin
                            d.st   = S_RDATA;
                            d.rbuf = rd_word;
                            d.par  = rd_par;
                        end else begin
                            d.st = S_WDATA;
                        end
                    end
                end
                S_WDATA: begin
                    if (x_rise) begin
                        d.wbuf = (q.wbuf << NIB_W) | REG_W'(bus_in);
                        if (q.cnt == CNT_W'(REG_NIBS - 1)) begin
                            d.st      = S_ACK;
                            d.drv_en  = 1'b1;
                            d.drv_val = legal ? ACK_OK : ACK_BAD;
                            d.wr_en   = legal;
                        end else begin
                            d.cnt = q.cnt + CNT_W'(1);
                        end
                    end
                end
                S_ACK: begin
                    if (x_fall) begin
                        d.st     = S_DONE;
                        d.drv_en = 1'b0;
                    end
                end
                S_RDATA: begin
                    if (x_fall) begin
                        if (q.cnt < CNT_W'(STAT_NIBS)) begin
                            d.drv_en  = 1'b1;
                            d.drv_val = q.rbuf[STAT_W-1 -: NIB_W];
                            d.rbuf    = q.rbuf << NIB_W;
                            d.cnt     = q.cnt + CNT_W'(1);
                        end else if (q.cnt == CNT_W'(STAT_NIBS)) begin
                            d.drv_en  = 1'b1;
                            d.drv_val = q.par;
                            d.cnt     = q.cnt + CNT_W'(1);
                        end else begin
                            d.st     = S_DONE;
                            d.drv_en = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_OFF, default: '0};
        else        q <= d;
    end

    assign wr_en   = q.wr_en;
    assign wr_addr = q.addr;
    assign wr_data = q.wbuf;
    assign drv_en  = q.drv_en;
    assign drv_val = q.drv_val;
endmodule

// File: rtl/nibble_cmd_port.sv
module nibble_cmd_port
    import nbi_pkg::*;
#(
    parameter int NUM_REGS  = 6,
    parameter int REG_NIBS  = 2,
    parameter int NUM_STAT  = 8,
    parameter int STAT_NIBS = 2,
    localparam int REG_W    = REG_NIBS * NIB_W,
    localparam int STAT_W   = STAT_NIBS * NIB_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ce_n,
    input  logic                         xfer_clk,
    input  logic [3:0]                   bus_in,
    output logic [3:0]                   bus_oe,
    input  logic [3:0]                   dev_status,
    input  logic [NUM_STAT*STAT_W-1:0]   stat_words,
    output logic [NUM_REGS*REG_W-1:0]    cfg_regs
);
    logic [1:0]        s_lvl, s_rise, s_fall;
    logic              ce_hi, ce_fall, x_rise, x_fall;
    logic [SEL_W-1:0]  rd_sel;
    logic [STAT_W-1:0] rd_word;
    logic [NIB_W-1:0]  rd_par;
    logic              wr_en;
    logic [SEL_W-1:0]  wr_addr;
    logic [REG_W-1:0]  wr_data;
    logic              drv_en;
    logic [NIB_W-1:0]  drv_val;

    nbi_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ce_n, xfer_clk}),
        .lvl   (s_lvl),
        .rise  (s_rise),
        .fall  (s_fall)
    );

    assign ce_hi   = s_lvl[1];
    assign ce_fall = s_fall[1];
    assign x_rise  = s_rise[0];
    assign x_fall  = s_fall[0];

    nbi_rdmux #(.NUM_STAT(NUM_STAT), .STAT_NIBS(STAT_NIBS)) u_rdmux (
        .stat_words (stat_words),
        .sel        (rd_sel),
        .word       (rd_word),
        .par        (rd_par)
    );

    nbi_seq #(.NUM_REGS(NUM_REGS), .REG_NIBS(REG_NIBS), .STAT_NIBS(STAT_NIBS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_hi      (ce_hi),
        .ce_fall    (ce_fall),
        .x_rise     (x_rise),
        .x_fall     (x_fall),
        .bus_in     (bus_in),
        .dev_status (dev_status),
        .rd_word    (rd_word),
        .rd_par     (rd_par),
        .rd_sel     (rd_sel),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .drv_en     (drv_en),
        .drv_val    (drv_val)
    );

    nbi_regbank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs_o  (cfg_regs)
    );

    assign bus_oe = drv_en ? ~drv_val : '0;
endmodule

// File: rtl/nbi_chk.sv
module nbi_chk #(
    parameter int NUM_REGS = 6,
    parameter int REG_W    = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ce_hi,
    input logic                      ce_fall,
    input logic                      x_rise,
    input logic                      x_fall,
    input logic [3:0]                bus_oe,
    input logic                      wr_en,
    input logic [2:0]                wr_addr,
    input logic [NUM_REGS*REG_W-1:0] cfg_regs
);
    // R9
    ce_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_hi |=> bus_oe == 4'b0000);

    // R5
    legal_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> int'(wr_addr) < NUM_REGS);

    // R5
    ack_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> bus_oe == 4'b0101);

    // R11
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_regs));

    // R10
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_hi && !ce_fall && !x_rise && !x_fall) |=> $stable(bus_oe));
endmodule

bind nibble_cmd_port nbi_chk #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_hi    (ce_hi),
    .ce_fall  (ce_fall),
    .x_rise   (x_rise),
    .x_fall   (x_fall),
    .bus_oe   (bus_oe),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .cfg_regs (cfg_regs)
);

// File: tb/tb_nibble_cmd_port.sv
module tb_nibble_cmd_port;
    localparam int NREG = 6;
    localparam int NSTAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        xfer_clk = 1'b1;
    logic        host_en = 1'b0;
    logic [3:0]  host_val = 4'h0;
    logic [3:0]  bus_in;
    logic [3:0]  bus_oe;
    logic [3:0]  dev_status = 4'h0;
    logic [NSTAT*8-1:0] stat_words;
    logic [NREG*8-1:0]  cfg_regs;

    int errors = 0;
    int checks = 0;
    logic [7:0] mreg [NREG];

    typedef struct {
        int         kind;
        int         idx;
        logic [7:0] val;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    assign bus_in = host_en ? host_val : ~bus_oe;

    nibble_cmd_port dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .xfer_clk   (xfer_clk),
        .bus_in     (bus_in),
        .bus_oe     (bus_oe),
        .dev_status (dev_status),
        .stat_words (stat_words),
        .cfg_regs   (cfg_regs)
    );

    function automatic logic [7:0] sw(int i);
        return 8'(8'hC3 ^ (i * 37));
    endfunction

    initial begin
        for (int i = 0; i < NSTAT; i++) stat_words[i*8 +: 8] = sw(i);
        for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
    end

    // monitor: pops expectations and compares against the ports
    initial begin
        exp_t e;
        logic [7:0] got;
        forever begin
            wait (sb.size() != 0);
            e = sb.pop_front();
            checks++;
            if (e.kind == 0) got = {4'h0, bus_oe};
            else             got = cfg_regs[e.idx*8 +: 8];
            if (got !== e.val) begin
                errors++;
                $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", e.req, e.kind, e.idx, got, e.val);
            end
        end
    end

    task automatic settle();
        repeat (8) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic exp_bus(logic drive, logic [3:0] v, string r);
        exp_t e;
        e.kind = 0; e.idx = 0; e.req = r;
        e.val = drive ? {4'h0, ~v} : 8'h00;
        sb.push_back(e);
        #1;
    endtask

    task automatic exp_regs(string r);
        for (int i = 0; i < NREG; i++) begin
            exp_t e;
            e.kind = 1; e.idx = i; e.val = mreg[i]; e.req = r;
            sb.push_back(e);
        end
        #1;
    endtask

    task automatic x_fall();
        xfer_clk = 1'b0;
        settle();
    endtask

    task automatic x_rise_drv(logic [3:0] n);
        host_en = 1'b1;
        host_val = n;
        settle();
        xfer_clk = 1'b1;
        settle();
        host_en = 1'b0;
    endtask

    task automatic x_rise_free();
        xfer_clk = 1'b1;
        settle();
    endtask

    task automatic do_write(logic [3:0] op, logic [7:0] d, logic [3:0] st);
        logic legal;
        legal = int'(op[2:0]) < NREG;
        dev_status = st;
        ce_n = 1'b0; settle();
        exp_bus(1, st, "R2");
        x_fall();
        exp_bus(0, 4'h0, "R3");
        x_rise_drv(op);
        exp_bus(0, 4'h0, "R4");
        x_fall();
        x_rise_drv(d[7:4]);
        exp_bus(0, 4'h0, "R4");
        x_fall();
        x_rise_drv(d[3:0]);
        exp_bus(1, legal ? 4'hA : 4'h5, "R5");
        if (legal) mreg[op[2:0]] = d;
        x_fall();
        exp_bus(0, 4'h0, "R6");
        x_rise_free();
        x_fall();
        exp_bus(0, 4'h0, "R11");
        x_rise_free();
        ce_n = 1'b1; settle();
        exp_bus(0, 4'h0, "R9");
        exp_regs(legal ? "R4" : "R5");
    endtask

    task automatic do_read(logic [2:0] sel, logic [3:0] st);
        logic [7:0] w;
        w = sw(int'(sel));
        dev_status = st;
        ce_n = 1'b0; settle();
        exp_bus(1, st, "R2");
        x_fall();
        exp_bus(0, 4'h0, "R3");
        x_rise_drv({1'b1, sel});
        exp_bus(0, 4'h0, "R7");
        x_fall();
        exp_bus(1, w[7:4], "R7");
        x_rise_free();
        exp_bus(1, w[7:4], "R7");
        x_fall();
        exp_bus(1, w[3:0], "R7");
        x_rise_free();
        x_fall();
        exp_bus(1, w[7:4] ^ w[3:0], "R8");
        x_rise_free();
        x_fall();
        exp_bus(0, 4'h0, "R8");
        x_rise_free();
        ce_n = 1'b1; settle();
        exp_bus(0, 4'h0, "R9");
        exp_regs("R11");
    endtask

    logic done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        exp_bus(0, 4'h0, "R1");
        exp_regs("R1");

        // R11: clocks with select high
        x_fall(); x_rise_drv(4'h1); x_fall(); x_rise_free();
        exp_bus(0, 4'h0, "R11");
        exp_regs("R11");

        do_write(4'h0, 8'h5A, 4'h3);
        do_write(4'h5, 8'hC7, 4'hE);
        do_write(4'h2, 8'h0F, 4'h9);
        // R5 illegal addresses
        do_write(4'h6, 8'hFF, 4'h1);
        do_write(4'h7, 8'h12, 4'h6);
        do_write(4'h2, 8'hB4, 4'h0);

        do_read(3'd0, 4'h7);
        do_read(3'd3, 4'hB);
        do_read(3'd7, 4'h4);

        // R10 idle transaction
        dev_status = 4'hD;
        ce_n = 1'b0; settle();
        exp_bus(1, 4'hD, "R10");
        dev_status = 4'h2;
        settle(); settle(); settle();
        exp_bus(1, 4'hD, "R10");
        ce_n = 1'b1; settle();
        exp_bus(0, 4'h0, "R10");

        // R9 abort a write part-way
        dev_status = 4'h8;
        ce_n = 1'b0; settle();
        x_fall();
        x_rise_drv(4'h1);
        x_fall();
        x_rise_drv(4'h9);
        ce_n = 1'b1; settle();
        exp_bus(0, 4'h0, "R9");
        x_fall(); x_rise_drv(4'h3);
        exp_regs("R9");

        // R9 abort while status is driven
        ce_n = 1'b0; settle();
        exp_bus(1, 4'h8, "R2");
        ce_n = 1'b1; settle();
        exp_bus(0, 4'h0, "R9");

        settle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule